// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block gives a host access to a bank of 8-bit configuration registers through just two byte addresses. The lower address holds an index pointer; the upper address is a data window onto whichever register the pointer names. After reset the space is closed. The host opens it by writing a fixed key byte to the lower address twice with no other bus write in between. While the space is closed, data writes do nothing and every read returns 0xFF. A separate closing byte written to the lower address shuts the space again.

Inside the space, a few global registers are handled locally:
- a logical-device selector;
- a read-only chip identifier;
- an activate flag for each logical device.

Indices from 0x60 upward are passed to the selected logical device through a small register-file interface. For example, device 0x08 carries the watchdog registers. A build parameter swaps the default key pair for an alternate pair used by a companion-chip variant.

Top module: `cfgp_top`

## Requirements
- R1: After reset the space is closed. While closed, a read of either address returns 0xFF, and a write to the data address (bus_addr=1) changes no register and raises no dev_we.
- R2: The space opens after the unlock key is written to the index address (bus_addr=0) twice, with no other bus write between the two. The unlock key is 0x87 by default. Idle and read cycles between the two writes are allowed. Key writes do not load the index register.
- R3: Any bus write other than the expected second key byte sends the unlock sequence back to its start. This includes a write to the data address or a different byte to the index address.
- R4: While open, writing the lock key to the index address closes the space and leaves the index unchanged. The lock key is 0xAA by default.
- R5: With ALT_KEYS=1, the unlock key is 0x88 and the lock key is 0xBB. The default pair then has no effect.
- R6: While open, any other write to the index address loads the index register. A read of the index address returns the index.
- R7: Index 0x07 is an 8-bit read/write logical-device number, reset to 0x00. It can change only while the space is open.
- R8: Index 0x20 reads as the CHIP_ID parameter (default 0x52). Writes to it are ignored.
- R9: Index 0x30 bit 0 is the activate flag of the selected device. It is driven on dev_active[n] for device n. Bits 7:1 read 0. For a device number of NUM_DEV or above, index 0x30 reads 0x00 and writes are ignored.
- R10: An index of 0x60 or above is forwarded to the selected device. dev_sel carries the device number and dev_idx carries the index. A data write while open pulses dev_we for one cycle with dev_wdata. A read returns dev_rdata.
- R11: Other indices below 0x60 read 0x00 and ignore writes. Reads are combinational. Writes take effect on the clock edge that samples bus_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 1 | 0 = index/key address, 1 = data address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (combinational) |
| dev_sel | output | 8 | Selected logical-device number |
| dev_idx | output | 8 | Register index forwarded to the device |
| dev_we | output | 1 | One-cycle write strobe to the device |
| dev_wdata | output | 8 | Write byte to the device |
| dev_rdata | input | 8 | Read byte from the selected device |
| dev_active | output | NUM_DEV | Activate flag of each logical device |

## Verification
The hardest state to reach is a half-finished unlock sequence that is then disturbed. The bench lands a first key byte and then interposes either a data-address write or a near-miss key byte. It then shows that the next key byte only re-arms the sequence, and that a further key byte opens the space.

A second instance built with the alternate keys shares the same bus. Each key pair can therefore be shown to open one instance while leaving the other closed. Device banking is exposed by writing a forwarded register under one device number and reading the same index under another.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_HALF   = 2'd1,
    ST_OPEN   = 2'd2
  } lock_st_t;

  localparam logic [7:0] IDX_LDN    = 8'h07;
  localparam logic [7:0] IDX_CHIPID = 8'h20;
  localparam logic [7:0] IDX_ACT    = 8'h30;
  localparam logic [7:0] WIN_BASE   = 8'h60;
  localparam logic [7:0] CLOSED_RD  = 8'hFF;

  function automatic logic [7:0] unlock_key(input bit alt);
    return alt ? 8'h88 : 8'h87;
  endfunction

  function automatic logic [7:0] lock_key(input bit alt);
    return alt ? 8'hBB : 8'hAA;
  endfunction

  function automatic logic in_window(input logic [7:0] idx);
    return idx >= WIN_BASE;
  endfunction

endpackage

// File: rtl/cfgp_keyfsm.sv
module cfgp_keyfsm
  import cfgp_pkg::*;
#(
  parameter bit ALT_KEYS = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic       cfg_open,
  output logic       ev_open,
  output logic       ev_close,
  output logic       ev_abort
);

  logic [7:0] key_on;
  logic [7:0] key_off;

  generate
    if (ALT_KEYS) begin : g_alt
      assign key_on  = unlock_key(1'b1);
      assign key_off = lock_key(1'b1);
    end else begin : g_std
      assign key_on  = unlock_key(1'b0);
      assign key_off = lock_key(1'b0);
    end
  endgenerate

  lock_st_t st_q, st_d;
  logic     hit_on, hit_off;

  assign hit_on  = wr && !addr && (wdata == key_on);
  assign hit_off = wr && !addr && (wdata == key_off);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_LOCKED: if (hit_on) st_d = ST_HALF;
      ST_HALF: begin
        if (hit_on)  st_d = ST_OPEN;
        else if (wr) st_d = ST_LOCKED;
      end
      ST_OPEN:   if (hit_off) st_d = ST_LOCKED;
      default:   st_d = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_LOCKED;
    else        st_q <= st_d;
  end

  assign cfg_open = (st_q == ST_OPEN);
  assign ev_open  = (st_q == ST_HALF) && (st_d == ST_OPEN);
  assign ev_close = (st_q == ST_OPEN) && (st_d == ST_LOCKED);
  assign ev_abort = (st_q == ST_HALF) && (st_d == ST_LOCKED);

endmodule

// File: rtl/cfgp_actbank.sv
module cfgp_actbank #(
  parameter int NUM_DEV = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [7:0]         sel,
  input  logic               wbit,
  output logic [NUM_DEV-1:0] act_vec,
  output logic               sel_valid,
  output logic               rd_bit
);

  localparam int         SEL_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam logic [8:0] LIMIT_9 = 9'(NUM_DEV);

  logic [SEL_W-1:0] sel_n;

  assign sel_valid = ({1'b0, sel} < LIMIT_9);
  assign sel_n     = sel[SEL_W-1:0];

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        act_vec[d] <= 1'b0;
      else if (we && sel_valid && (32'(sel_n) == d))
        act_vec[d] <= wbit;
    end
  end

  assign rd_bit = sel_valid ? act_vec[sel_n] : 1'b0;

endmodule

// File: rtl/cfgp_top.sv
module cfgp_top
  import cfgp_pkg::*;
#(
  parameter int         NUM_DEV  = 16,
  parameter logic [7:0] CHIP_ID  = 8'h52,
  parameter bit         ALT_KEYS = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  output logic [7:0]         dev_sel,
  output logic [7:0]         dev_idx,
  output logic               dev_we,
  output logic [7:0]         dev_wdata,
  input  logic [7:0]         dev_rdata,
  output logic [NUM_DEV-1:0] dev_active
);

  logic       cfg_open, ev_open, ev_close, ev_abort;
  logic [7:0] idx_q, ldn_q;
  logic       idx_load, data_wr, act_we, act_rd, sel_valid;

  cfgp_keyfsm #(.ALT_KEYS(ALT_KEYS)) u_key (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .cfg_open(cfg_open), .ev_open(ev_open),
    .ev_close(ev_close), .ev_abort(ev_abort)
  );

  // index register: loaded by open-space writes that are not the closing key
  assign idx_load = cfg_open && bus_wr && !bus_addr && !ev_close;
  assign data_wr  = cfg_open && bus_wr && bus_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idx_q <= 8'h00;
    else if (idx_load) idx_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             ldn_q <= 8'h00;
    else if (data_wr && idx_q == IDX_LDN)   ldn_q <= bus_wdata;
  end

  assign act_we = data_wr && (idx_q == IDX_ACT);

  cfgp_actbank #(.NUM_DEV(NUM_DEV)) u_act (
    .clk(clk), .rst_n(rst_n), .we(act_we), .sel(ldn_q),
    .wbit(bus_wdata[0]), .act_vec(dev_active), .sel_valid(sel_valid),
    .rd_bit(act_rd)
  );

  assign dev_sel   = ldn_q;
  assign dev_idx   = idx_q;
  assign dev_wdata = bus_wdata;
  assign dev_we    = data_wr && in_window(idx_q);

  logic [7:0] reg_rd;
  always_comb begin
    if (in_window(idx_q))          reg_rd = dev_rdata;
    else if (idx_q == IDX_LDN)     reg_rd = ldn_q;
    else if (idx_q == IDX_CHIPID)  reg_rd = CHIP_ID;
    else if (idx_q == IDX_ACT)     reg_rd = {7'b0, act_rd};
    else                           reg_rd = 8'h00;
  end

  always_comb begin
    if (!cfg_open)     bus_rdata = CLOSED_RD;
    else if (bus_addr) bus_rdata = reg_rd;
    else               bus_rdata = idx_q;
  end

endmodule

// File: rtl/cfgp_chk.sv
module cfgp_chk #(
  parameter logic [7:0] CHIP_ID  = 8'h52,
  parameter bit         ALT_KEYS = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_addr,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       cfg_open,
  input logic       dev_we,
  input logic [7:0] ldn_q,
  input logic [7:0] idx_q
);

  localparam logic [7:0] UK = ALT_KEYS ? 8'h88 : 8'h87;
  localparam logic [7:0] LK = ALT_KEYS ? 8'hBB : 8'hAA;

  // R1
  a_r1_closed_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && bus_rd) |-> (bus_rdata == 8'hFF));

  // R2
  a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(bus_wr && !bus_addr && bus_wdata == UK));

  // R4
  a_r4_lock_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && bus_wr && !bus_addr && bus_wdata == LK) |=> !cfg_open);

  // R4
  a_r4_lock_keeps_index: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && bus_wr && !bus_addr && bus_wdata == LK) |=> $stable(idx_q));

  // R7
  a_r7_ldn_frozen_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable(ldn_q));

  // R8
  a_r8_chip_id: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && bus_rd && bus_addr && idx_q == 8'h20) |-> (bus_rdata == CHIP_ID));

  // R10
  a_r10_dev_we_gated: assert property (@(posedge clk) disable iff (!rst_n)
    dev_we |-> (cfg_open && bus_wr && bus_addr));

endmodule

bind cfgp_top cfgp_chk #(.CHIP_ID(CHIP_ID), .ALT_KEYS(ALT_KEYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .cfg_open(cfg_open), .dev_we(dev_we), .ldn_q(ldn_q), .idx_q(idx_q)
);

// File: tb/cfgp_top_tb.sv
`timescale 1ns/1ps
module cfgp_top_tb;

  localparam int NUM_DEV = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_addr = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata, alt_rdata;
  logic [7:0] dev_sel, dev_idx, dev_wdata, dev_rdata;
  logic       dev_we;
  logic [NUM_DEV-1:0] dev_active;
  logic [7:0] a_sel, a_idx, a_wdata;
  logic       a_we;
  logic [NUM_DEV-1:0] a_active;

  always #10 clk = ~clk; // 50 MHz

  cfgp_top #(.NUM_DEV(NUM_DEV)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dev_sel(dev_sel), .dev_idx(dev_idx), .dev_we(dev_we),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_active(dev_active)
  );

  cfgp_top #(.NUM_DEV(NUM_DEV), .ALT_KEYS(1'b1)) u_alt (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(alt_rdata),
    .dev_sel(a_sel), .dev_idx(a_idx), .dev_we(a_we),
    .dev_wdata(a_wdata), .dev_rdata(8'h00), .dev_active(a_active)
  );

  // model of the device register banks behind the forwarding window
  logic [7:0] devmem [0:4095];
  assign dev_rdata = devmem[{dev_sel[3:0], dev_idx}];
  always @(posedge clk) if (dev_we) devmem[{dev_sel[3:0], dev_idx}] <= dev_wdata;

  typedef struct {
    logic [7:0] e_main;
    logic [7:0] e_alt;
    bit         chk_alt;
    string      tag;
  } exp_t;
  exp_t sb[$];

  int n_cmp = 0;
  int n_bad = 0;

  task automatic wr(input logic a, input logic [7:0] d);
    @(posedge clk); #5;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #5;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] em, input bit ca,
                    input logic [7:0] ea, input string tag);
    exp_t it;
    it.e_main = em; it.e_alt = ea; it.chk_alt = ca; it.tag = tag;
    @(posedge clk); #5;
    sb.push_back(it);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #5;
    bus_rd = 1'b0;
  endtask

  task automatic chk_act(input logic [NUM_DEV-1:0] e, input string tag);
    @(negedge clk);
    n_cmp++;
    if (dev_active !== e) begin
      n_bad++;
      $display("FAIL %s: dev_active act=%h exp=%h", tag, dev_active, e);
    end
  endtask

  // monitor: compare each read against the queued expectation
  always @(negedge clk) begin
    if (rst_n && bus_rd) begin
      if (sb.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard: read with no expectation act=%h exp=none", bus_rdata);
      end else begin
        exp_t it;
        it = sb.pop_front();
        n_cmp++;
        if (bus_rdata !== it.e_main) begin
          n_bad++;
          $display("FAIL %s: act=%h exp=%h", it.tag, bus_rdata, it.e_main);
        end
        if (it.chk_alt) begin
          n_cmp++;
          if (alt_rdata !== it.e_alt) begin
            n_bad++;
            $display("FAIL %s (alt keys): act=%h exp=%h", it.tag, alt_rdata, it.e_alt);
          end
        end
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: act=timeout exp=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4096; i++) devmem[i] = 8'h00;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;

    // R1 reset state
    rd(1'b1, 8'hFF, 1'b1, 8'hFF, "R1 closed data read");
    rd(1'b0, 8'hFF, 1'b1, 8'hFF, "R1 closed index read");
    chk_act('0, "R1 reset activate flags");
    wr(1'b1, 8'h55);                       // ignored while closed
    // R2 unlock with default key
    wr(1'b0, 8'h87);
    rd(1'b1, 8'hFF, 1'b0, 8'h00, "R2 one key not enough");
    wr(1'b0, 8'h87);
    rd(1'b0, 8'h00, 1'b1, 8'hFF, "R2 open, key not loaded into index");
    wr(1'b0, 8'h07);
    rd(1'b1, 8'h00, 1'b0, 8'h00, "R1 locked data write had no effect");
    // R8 chip id, write ignored
    wr(1'b0, 8'h20);
    rd(1'b1, 8'h52, 1'b0, 8'h00, "R8 chip id");
    wr(1'b1, 8'h00);
    rd(1'b1, 8'h52, 1'b0, 8'h00, "R8 chip id write ignored");
    // R4 lock keeps index
    wr(1'b0, 8'hAA);
    rd(1'b1, 8'hFF, 1'b1, 8'hFF, "R4 closed after lock key");
    wr(1'b0, 8'h87); wr(1'b0, 8'h87);
    rd(1'b0, 8'h20, 1'b0, 8'h00, "R4 index kept across lock");
    wr(1'b0, 8'hAA);

    // R3 disturbed sequences
    wr(1'b0, 8'h87); wr(1'b1, 8'h00); wr(1'b0, 8'h87);
    rd(1'b1, 8'hFF, 1'b0, 8'h00, "R3 data write restarts sequence");
    wr(1'b0, 8'h87);
    rd(1'b0, 8'h20, 1'b0, 8'h00, "R3 re-armed key then opens");
    wr(1'b0, 8'hAA);
    wr(1'b0, 8'h87); wr(1'b0, 8'h86); wr(1'b0, 8'h87);
    rd(1'b0, 8'hFF, 1'b0, 8'h00, "R3 near-miss byte restarts sequence");
    wr(1'b0, 8'h00);                       // abort any half sequence

    // R5 alternate keys
    wr(1'b0, 8'h88); wr(1'b0, 8'h88);
    rd(1'b0, 8'hFF, 1'b1, 8'h00, "R5 alt pair opens only alt instance");
    wr(1'b0, 8'hAA);
    rd(1'b1, 8'hFF, 1'b1, 8'h00, "R5 default lock key no effect on alt");
    wr(1'b0, 8'hBB);
    rd(1'b1, 8'hFF, 1'b1, 8'hFF, "R5 alt lock key closes alt");

    // R6, R7 index and device select
    wr(1'b0, 8'h87); wr(1'b0, 8'h87);
    wr(1'b0, 8'h07);
    rd(1'b0, 8'h07, 1'b0, 8'h00, "R6 index readback");
    wr(1'b1, 8'h08);
    rd(1'b1, 8'h08, 1'b0, 8'h00, "R7 device select");
    // R9 activate
    wr(1'b0, 8'h30); wr(1'b1, 8'hFF);
    rd(1'b1, 8'h01, 1'b0, 8'h00, "R9 activate bit0 only");
    chk_act(16'h0100, "R9 dev_active device 8");
    // R10 forwarding window
    wr(1'b0, 8'hF6); wr(1'b1, 8'h3C);
    rd(1'b1, 8'h3C, 1'b0, 8'h00, "R10 window write/read device 8");
    wr(1'b0, 8'h07); wr(1'b1, 8'h03);
    wr(1'b0, 8'hF6);
    rd(1'b1, 8'h00, 1'b0, 8'h00, "R10 banked by device select");
    wr(1'b0, 8'h30);
    rd(1'b1, 8'h00, 1'b0, 8'h00, "R9 device 3 inactive");
    // R9 out-of-range device
    wr(1'b0, 8'h07); wr(1'b1, 8'h1F);
    wr(1'b0, 8'h30); wr(1'b1, 8'h01);
    rd(1'b1, 8'h00, 1'b0, 8'h00, "R9 out-of-range device reads 0");
    chk_act(16'h0100, "R9 out-of-range write ignored");
    // R11 unmapped index
    wr(1'b0, 8'h40); wr(1'b1, 8'h77);
    rd(1'b1, 8'h00, 1'b0, 8'h00, "R11 unmapped index reads 0");
    wr(1'b0, 8'hAA);
    rd(1'b1, 8'hFF, 1'b1, 8'hFF, "R4 final close");

    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule